// File: doc/BRIEF.md
# I2C Slave Address Matcher with General Call

This block is the receive front end of an I2C slave. It watches the already-synchronised SCL and SDA lines for a Start condition. After a Start it shifts in the first byte and compares that byte with a programmable own address and with the fixed general-call code. When the byte is accepted, the block pulls SDA low for the acknowledge clock. It loads a receive buffer, raises a buffer-full flag at the eighth bit, and raises an interrupt flag on the SCL falling edge that ends the ninth clock. Later bytes of an accepted transfer are received as data in the same way.

Two addressing modes are supported. In 7-bit mode a single address byte selects the device. In 10-bit mode a match on the first address half raises an update-address flag. Software then loads the low half into the same own-address input and pulses `addrLoad`, and the second byte must equal it exactly. A general call, when enabled, is recognised in either mode. In 10-bit mode a general call skips the second address byte and goes straight to data. A status output tells software whether the last accepted address was a general call.

Software clears the flags through single-cycle pulse inputs. Every control input is a plain level or strobe.

Top module: `i2cAddrMatch`

## Requirements
- R1: A Start (SDA falling while SCL is high) begins address reception from any state, a repeated Start included. A Stop (SDA rising while SCL is high) returns the block to idle, releases SDA, and causes later bytes to be ignored until the next Start. Reset clears every output to 0.
- R2: Bits are sampled on the SCL rising edge, most significant bit first. An accepted byte appears on `rxBuf` from the eighth rising edge onward.
- R3: In 7-bit mode (`tenBit`=0) an address byte is accepted when bits 7..1 equal `ownAddr[7:1]` and bit 0 (R/W) is 0. `sdaLow` is 1 from the SCL falling edge after bit 8 until the falling edge after bit 9. A read request (bit 0 = 1) is not acknowledged.
- R4: The address byte 0x00 is accepted as a general call only while `gcEn` is 1. While `gcEn` is 0 it is accepted only if it matches the own address.
- R5: An address byte that does not match gets no acknowledge and changes no flag or buffer. Later bytes up to the next Start are ignored.
- R6: `bufFull` goes to 1 on the eighth rising edge of every accepted byte and is cleared by a `bufRead` pulse. If both happen in one cycle, the set wins.
- R7: `irq` goes to 1 on the SCL falling edge that ends the ninth clock of an acknowledged byte, and is cleared by an `irqClr` pulse.
- R8: A byte that would be accepted while `bufFull` is 1 sets `overflow` and is not acknowledged. It leaves `rxBuf` unchanged and raises no `irq`, and the block goes idle afterwards. `ovfClr` clears `overflow`.
- R9: In 10-bit mode a first-half match (bits 7..1 equal to `ownAddr[7:1]`, R/W=0) sets `updAddr`. The next byte is then accepted only if all 8 bits equal `ownAddr`. `addrLoad` clears `updAddr`.
- R10: In 10-bit mode an accepted general call leaves `updAddr` at 0, and the byte that follows it is received as data.
- R11: After an accepted address, each following byte is received as data. It is acknowledged, loaded into `rxBuf`, and raises `bufFull` and `irq`.
- R12: `gcFlag` is updated with every accepted first address byte: 1 for a general call, 0 for an own-address match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| scl | input | 1 | Synchronised SCL level |
| sdaIn | input | 1 | Synchronised SDA bus level |
| sdaLow | output | 1 | 1 = pull SDA low (acknowledge) |
| ownAddr | input | 8 | Own address register value |
| gcEn | input | 1 | General-call recognition enable |
| tenBit | input | 1 | 1 = 10-bit addressing mode |
| bufRead | input | 1 | Pulse: buffer has been read, clears bufFull |
| irqClr | input | 1 | Pulse: clear irq |
| ovfClr | input | 1 | Pulse: clear overflow |
| addrLoad | input | 1 | Pulse: own address reloaded, clears updAddr |
| rxBuf | output | 8 | Receive buffer |
| bufFull | output | 1 | Buffer holds an unread byte |
| overflow | output | 1 | Byte arrived while buffer was full |
| irq | output | 1 | Interrupt flag |
| updAddr | output | 1 | Own address must be reloaded (10-bit) |
| gcFlag | output | 1 | Last accepted address was a general call |

## Verification
A wrong bit counter or phase shows up within a single SCL period. `sdaLow` then rises on the wrong falling edge, or the buffer loads a byte shifted by one position. A bench compares both every clock, so the fault is reported in the very cycle it first reaches a port. A phase error, for example entering data reception after a mismatch or in 10-bit mode after a general call, shows one byte later. It appears as a spurious acknowledge, or as `updAddr` rising when it should not. A flag set/clear priority fault appears on the clock where a software pulse meets an eighth bit or a ninth falling edge.

// File: rtl/i2cAddrMatchPkg.sv
package i2cAddrMatchPkg;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_ADDR_HI = 2'd1,
    PH_ADDR_LO = 2'd2,
    PH_DATA    = 2'd3
  } phaseT;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftBit;
    logic loadBuf;
    logic setOvf;
    logic setIrq;
    logic setUa;
    logic latchGc;
    logic gcVal;
  } strobeT;

  // compare results from datapath to control
  typedef struct packed {
    logic ownHi;
    logic ownFull;
    logic gcHit;
    logic bufBusy;
  } matchT;

endpackage

// File: rtl/i2cAddrMatchData.sv
module i2cAddrMatchData
  import i2cAddrMatchPkg::*;
#(
  parameter int BYTE_W = 8,
  parameter logic [BYTE_W-1:0] GC_CODE = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sdaIn,
  input  logic [BYTE_W-1:0] ownAddr,
  input  logic              gcEn,
  input  logic              bufRead,
  input  logic              irqClr,
  input  logic              ovfClr,
  input  logic              addrLoad,
  input  strobeT            strobe,
  output matchT             match,
  output logic [BYTE_W-1:0] rxBuf,
  output logic              bufFull,
  output logic              overflow,
  output logic              irq,
  output logic              updAddr,
  output logic              gcFlag
);

  logic [BYTE_W-1:0] shiftReg;
  logic [BYTE_W-1:0] shiftNext;

  // byte including the bit being sampled at this edge
  assign shiftNext = {shiftReg[BYTE_W-2:0], sdaIn};

  always_comb begin
    match.ownHi   = (shiftNext[BYTE_W-1:1] == ownAddr[BYTE_W-1:1]) && !shiftNext[0];
    match.ownFull = (shiftNext == ownAddr);
    match.gcHit   = gcEn && (shiftNext == GC_CODE);
    match.bufBusy = bufFull;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      rxBuf    <= '0;
      bufFull  <= 1'b0;
      overflow <= 1'b0;
      irq      <= 1'b0;
      updAddr  <= 1'b0;
      gcFlag   <= 1'b0;
    end else begin
      if (strobe.shiftBit) shiftReg <= shiftNext;
      if (strobe.loadBuf)  rxBuf    <= shiftNext;
      bufFull  <= strobe.loadBuf | (bufFull & ~bufRead);
      overflow <= strobe.setOvf  | (overflow & ~ovfClr);
      irq      <= strobe.setIrq  | (irq & ~irqClr);
      updAddr  <= strobe.setUa   | (updAddr & ~addrLoad);
      if (strobe.latchGc) gcFlag <= strobe.gcVal;
    end
  end

endmodule

// File: rtl/i2cAddrMatchCtrl.sv
module i2cAddrMatchCtrl
  import i2cAddrMatchPkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   scl,
  input  logic   sdaIn,
  input  logic   tenBit,
  input  matchT  match,
  output strobeT strobe,
  output logic   sdaLow
);

  localparam int CNT_W = $clog2(BYTE_W + 2);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] ACK_DONE = CNT_W'(BYTE_W + 1);

  logic             sclQ, sdaQ;
  logic             sclRise, sclFall, startSeen, stopSeen;
  phaseT            phase, pendPhase, nextSel;
  logic [CNT_W-1:0] bitCnt;
  logic             accepted;
  logic             active;
  logic             wantAccept, isGc;
  logic             byteDone, takeByte, overByte;

  assign sclRise   = scl & ~sclQ;
  assign sclFall   = ~scl & sclQ;
  assign startSeen = scl & sclQ & sdaQ & ~sdaIn;
  assign stopSeen  = scl & sclQ & ~sdaQ & sdaIn;
  assign active    = (phase != PH_IDLE);

  always_comb begin
    wantAccept = 1'b0;
    isGc       = 1'b0;
    case (phase)
      PH_ADDR_HI: begin
        isGc       = match.gcHit;
        wantAccept = match.gcHit | match.ownHi;
      end
      PH_ADDR_LO: wantAccept = match.ownFull;
      PH_DATA:    wantAccept = 1'b1;
      default:    wantAccept = 1'b0;
    endcase
  end

  assign byteDone = active & sclRise & (bitCnt == LAST_BIT);
  assign takeByte = byteDone & wantAccept & ~match.bufBusy;
  assign overByte = byteDone & wantAccept & match.bufBusy;

  always_comb begin
    if (!takeByte)                                  nextSel = PH_IDLE;
    else if (phase == PH_ADDR_HI && tenBit && !isGc) nextSel = PH_ADDR_LO;
    else                                            nextSel = PH_DATA;
  end

  always_comb begin
    strobe.shiftBit = active & sclRise & (bitCnt < ACK_SLOT);
    strobe.loadBuf  = takeByte;
    strobe.setOvf   = overByte;
    strobe.latchGc  = takeByte & (phase == PH_ADDR_HI);
    strobe.gcVal    = isGc;
    strobe.setUa    = takeByte & (phase == PH_ADDR_HI) & tenBit & ~isGc;
    strobe.setIrq   = active & sclFall & (bitCnt == ACK_DONE) & accepted;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclQ      <= 1'b1;
      sdaQ      <= 1'b1;
      phase     <= PH_IDLE;
      pendPhase <= PH_IDLE;
      bitCnt    <= '0;
      accepted  <= 1'b0;
      sdaLow    <= 1'b0;
    end else begin
      sclQ <= scl;
      sdaQ <= sdaIn;
      if (startSeen) begin
        phase    <= PH_ADDR_HI;
        bitCnt   <= '0;
        accepted <= 1'b0;
        sdaLow   <= 1'b0;
      end else if (stopSeen) begin
        phase    <= PH_IDLE;
        accepted <= 1'b0;
        sdaLow   <= 1'b0;
      end else if (active) begin
        if (sclRise) begin
          if (byteDone) begin
            accepted  <= takeByte;
            pendPhase <= nextSel;
          end
          if (bitCnt < ACK_DONE) bitCnt <= bitCnt + 1'b1;
        end else if (sclFall) begin
          if (bitCnt == ACK_SLOT) begin
            sdaLow <= accepted;
          end else if (bitCnt == ACK_DONE) begin
            sdaLow <= 1'b0;
            phase  <= pendPhase;
            bitCnt <= '0;
          end
        end
      end
    end
  end

endmodule

// File: rtl/i2cAddrMatch.sv
module i2cAddrMatch
  import i2cAddrMatchPkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              scl,
  input  logic              sdaIn,
  output logic              sdaLow,
  input  logic [BYTE_W-1:0] ownAddr,
  input  logic              gcEn,
  input  logic              tenBit,
  input  logic              bufRead,
  input  logic              irqClr,
  input  logic              ovfClr,
  input  logic              addrLoad,
  output logic [BYTE_W-1:0] rxBuf,
  output logic              bufFull,
  output logic              overflow,
  output logic              irq,
  output logic              updAddr,
  output logic              gcFlag
);

  strobeT strobe;
  matchT  match;

  i2cAddrMatchCtrl #(.BYTE_W(BYTE_W)) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .scl    (scl),
    .sdaIn  (sdaIn),
    .tenBit (tenBit),
    .match  (match),
    .strobe (strobe),
    .sdaLow (sdaLow)
  );

  i2cAddrMatchData #(.BYTE_W(BYTE_W)) uData (
    .clk      (clk),
    .rstN     (rstN),
    .sdaIn    (sdaIn),
    .ownAddr  (ownAddr),
    .gcEn     (gcEn),
    .bufRead  (bufRead),
    .irqClr   (irqClr),
    .ovfClr   (ovfClr),
    .addrLoad (addrLoad),
    .strobe   (strobe),
    .match    (match),
    .rxBuf    (rxBuf),
    .bufFull  (bufFull),
    .overflow (overflow),
    .irq      (irq),
    .updAddr  (updAddr),
    .gcFlag   (gcFlag)
  );

endmodule

// File: rtl/i2cAddrMatchChecker.sv
module i2cAddrMatchChecker #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              scl,
  input logic              sdaIn,
  input logic              sdaLow,
  input logic              tenBit,
  input logic [BYTE_W-1:0] rxBuf,
  input logic              bufFull,
  input logic              overflow,
  input logic              irq,
  input logic              updAddr,
  input logic              gcFlag
);

  // R3: acknowledge is only asserted after an SCL falling edge
  a_r3_ack_on_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaLow) |-> !$past(scl));

  // R6: buffer-full rises on an SCL rising edge
  a_r6_bf_on_scl_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bufFull) |-> $past(scl));

  // R7: interrupt rises on a falling edge that ends an acknowledged clock
  a_r7_irq_after_ack: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> (!$past(scl) && $past(sdaLow)));

  // R8: overflow leaves the buffer untouched
  a_r8_buf_held_on_ovf: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overflow) |-> $stable(rxBuf));

  // R1: a Stop releases SDA
  a_r1_stop_releases: assert property (@(posedge clk) disable iff (!rstN)
    (scl && $past(scl) && !$past(sdaIn) && sdaIn) |=> !sdaLow);

  // R9: update-address flag only in 10-bit mode
  a_r9_ua_ten_bit_only: assert property (@(posedge clk) disable iff (!rstN)
    $rose(updAddr) |-> tenBit);

  // R10: a general call never raises update-address
  a_r10_no_ua_on_gc: assert property (@(posedge clk) disable iff (!rstN)
    $rose(updAddr) |-> !gcFlag);

endmodule

bind i2cAddrMatch i2cAddrMatchChecker #(.BYTE_W(BYTE_W)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .scl      (scl),
  .sdaIn    (sdaIn),
  .sdaLow   (sdaLow),
  .tenBit   (tenBit),
  .rxBuf    (rxBuf),
  .bufFull  (bufFull),
  .overflow (overflow),
  .irq      (irq),
  .updAddr  (updAddr),
  .gcFlag   (gcFlag)
);

// File: tb/tb_i2cAddrMatch.sv
`timescale 1ns/1ps
module tb_i2cAddrMatch;

  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1;
  logic sdaM = 1'b1;
  logic sdaBus;
  logic sdaLow;
  logic [7:0] ownAddr = 8'hB4;
  logic gcEn = 1'b0, tenBit = 1'b0;
  logic bufRead = 1'b0, irqClr = 1'b0, ovfClr = 1'b0, addrLoad = 1'b0;
  logic [7:0] rxBuf;
  logic bufFull, overflow, irq, updAddr, gcFlag;

  int checks = 0;
  int fails = 0;
  bit ackSeen;

  always #10 clk = ~clk;

  assign sdaBus = sdaM & ~sdaLow;

  i2cAddrMatch dut (
    .clk(clk), .rstN(rstN), .scl(scl), .sdaIn(sdaBus), .sdaLow(sdaLow),
    .ownAddr(ownAddr), .gcEn(gcEn), .tenBit(tenBit),
    .bufRead(bufRead), .irqClr(irqClr), .ovfClr(ovfClr), .addrLoad(addrLoad),
    .rxBuf(rxBuf), .bufFull(bufFull), .overflow(overflow), .irq(irq),
    .updAddr(updAddr), .gcFlag(gcFlag)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int mPh, mCnt, mSh, mNxt, mBuf;
  bit mAcc, mAck, mBf, mOvf, mIrq, mUa, mGc, pS, pD;

  always @(posedge clk) begin
    bit rise, fall, st, sp, oldBf, ownH, gcH, want;
    if (!rstN) begin
      mPh = 0; mCnt = 0; mSh = 0; mNxt = 0; mBuf = 0;
      mAcc = 0; mAck = 0; mBf = 0; mOvf = 0; mIrq = 0; mUa = 0; mGc = 0;
      pS = 1; pD = 1;
    end else begin
      rise = scl && !pS;
      fall = !scl && pS;
      st = scl && pS && pD && !sdaBus;
      sp = scl && pS && !pD && sdaBus;
      oldBf = mBf;
      if (bufRead) mBf = 0;
      if (irqClr) mIrq = 0;
      if (ovfClr) mOvf = 0;
      if (addrLoad) mUa = 0;
      if (st) begin
        mPh = 1; mCnt = 0; mAck = 0; mAcc = 0;
      end else if (sp) begin
        mPh = 0; mAck = 0; mAcc = 0;
      end else if (mPh != 0) begin
        if (rise && mCnt < 8) begin
          mSh = ((mSh << 1) | int'(sdaBus)) & 255;
          mCnt++;
          if (mCnt == 8) begin
            ownH = ((mSh >> 1) == int'(ownAddr >> 1)) && (mSh % 2 == 0);
            gcH = gcEn && (mSh == 0);
            want = (mPh == 1) ? (gcH || ownH) : (mPh == 2) ? (mSh == int'(ownAddr)) : 1'b1;
            if (want && !oldBf) begin
              mBuf = mSh; mBf = 1; mAcc = 1;
              if (mPh == 1) begin
                mGc = gcH;
                if (tenBit && !gcH) mUa = 1;
              end
              mNxt = (mPh == 1 && tenBit && !gcH) ? 2 : 3;
            end else begin
              if (want) mOvf = 1;
              mAcc = 0; mNxt = 0;
            end
          end
        end else if (rise && mCnt == 8) begin
          mCnt = 9;
        end else if (fall && mCnt == 8) begin
          mAck = mAcc;
        end else if (fall && mCnt == 9) begin
          mAck = 0;
          if (mAcc) mIrq = 1;
          mPh = mNxt; mCnt = 0;
        end
      end
      pS = scl; pD = sdaBus;
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      chk(sdaLow == mAck,        "R3 sdaLow",   int'(sdaLow),   int'(mAck));
      chk(int'(rxBuf) == mBuf,   "R2 rxBuf",    int'(rxBuf),    mBuf);
      chk(bufFull == mBf,        "R6 bufFull",  int'(bufFull),  int'(mBf));
      chk(overflow == mOvf,      "R8 overflow", int'(overflow), int'(mOvf));
      chk(irq == mIrq,           "R7 irq",      int'(irq),      int'(mIrq));
      chk(updAddr == mUa,        "R9 updAddr",  int'(updAddr),  int'(mUa));
      chk(gcFlag == mGc,         "R12 gcFlag",  int'(gcFlag),   int'(mGc));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic startCond();
    sdaM = 1'b1; tick(HALF);
    scl = 1'b1;  tick(HALF);
    sdaM = 1'b0; tick(HALF);
    scl = 1'b0;  tick(HALF);
  endtask

  task automatic stopCond();
    sdaM = 1'b0; tick(HALF);
    scl = 1'b1;  tick(HALF);
    sdaM = 1'b1; tick(HALF);
  endtask

  task automatic sendByte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; tick(HALF);
      scl = 1'b1;  tick(HALF);
      scl = 1'b0;
    end
    sdaM = 1'b1; tick(HALF);
    scl = 1'b1;  tick(2);
    ack = sdaLow;
    tick(HALF - 2);
    scl = 1'b0;  tick(HALF);
  endtask

  task automatic pulseRead();  bufRead = 1'b1;  tick(1); bufRead = 1'b0;  tick(1); endtask
  task automatic pulseIrq();   irqClr = 1'b1;   tick(1); irqClr = 1'b0;   tick(1); endtask
  task automatic pulseOvf();   ovfClr = 1'b1;   tick(1); ovfClr = 1'b0;   tick(1); endtask
  task automatic pulseLoad();  addrLoad = 1'b1; tick(1); addrLoad = 1'b0; tick(1); endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    tick(5);
    rstN = 1'b1;
    tick(2);
    // R1: reset state
    chk({sdaLow, rxBuf, bufFull, overflow, irq, updAddr, gcFlag} == '0, "R1 reset",
        int'({sdaLow, rxBuf, bufFull, overflow, irq, updAddr, gcFlag}), 0);

    // 7-bit own address, write
    startCond();
    sendByte(8'hB4, ackSeen);
    chk(ackSeen == 1'b1, "R3 own ack", int'(ackSeen), 1);
    chk(rxBuf == 8'hB4,  "R2 addr in buf", int'(rxBuf), 'hB4);
    chk(bufFull == 1'b1, "R6 bf set", int'(bufFull), 1);
    chk(irq == 1'b1,     "R7 irq set", int'(irq), 1);
    chk(gcFlag == 1'b0,  "R12 not gc", int'(gcFlag), 0);
    pulseRead(); pulseIrq();
    chk(bufFull == 1'b0 && irq == 1'b0, "R6 R7 cleared", int'({bufFull, irq}), 0);
    sendByte(8'h3C, ackSeen);
    chk(ackSeen == 1'b1 && rxBuf == 8'h3C, "R11 data byte", int'(rxBuf), 'h3C);
    // overflow: buffer not read
    sendByte(8'hA5, ackSeen);
    chk(ackSeen == 1'b0, "R8 nack on ovf", int'(ackSeen), 0);
    chk(overflow == 1'b1 && rxBuf == 8'h3C, "R8 ovf buf held", int'(rxBuf), 'h3C);
    pulseRead(); pulseIrq(); pulseOvf();
    sendByte(8'h11, ackSeen);
    chk(ackSeen == 1'b0 && bufFull == 1'b0, "R8 idle after ovf", int'(ackSeen), 0);
    stopCond();

    // mismatch and subsequent bytes ignored
    startCond();
    sendByte(8'hB6, ackSeen);
    chk(ackSeen == 1'b0 && bufFull == 1'b0, "R5 mismatch nack", int'(ackSeen), 0);
    sendByte(8'hB4, ackSeen);
    chk(ackSeen == 1'b0 && rxBuf == 8'h3C, "R5 ignored till start", int'(rxBuf), 'h3C);
    // read request
    startCond();
    sendByte(8'hB5, ackSeen);
    chk(ackSeen == 1'b0, "R3 read not acked", int'(ackSeen), 0);
    stopCond();

    // general call disabled, then enabled
    startCond();
    sendByte(8'h00, ackSeen);
    chk(ackSeen == 1'b0 && bufFull == 1'b0, "R4 gc disabled", int'(ackSeen), 0);
    gcEn = 1'b1;
    startCond();
    sendByte(8'h00, ackSeen);
    chk(ackSeen == 1'b1 && rxBuf == 8'h00, "R4 gc enabled", int'(ackSeen), 1);
    chk(gcFlag == 1'b1, "R12 gc flag", int'(gcFlag), 1);
    pulseRead(); pulseIrq();
    sendByte(8'h77, ackSeen);
    chk(ackSeen == 1'b1 && rxBuf == 8'h77, "R11 gc data", int'(rxBuf), 'h77);
    pulseRead(); pulseIrq();
    // repeated start mid-transfer
    startCond();
    sendByte(8'hB4, ackSeen);
    chk(ackSeen == 1'b1 && gcFlag == 1'b0, "R1 R12 repeated start", int'(gcFlag), 0);
    pulseRead(); pulseIrq();
    stopCond();
    sendByte(8'hB4, ackSeen);
    chk(ackSeen == 1'b0 && bufFull == 1'b0, "R1 ignored after stop", int'(ackSeen), 0);

    // 10-bit own address
    tenBit = 1'b1; ownAddr = 8'hF2;
    startCond();
    sendByte(8'hF2, ackSeen);
    chk(ackSeen == 1'b1 && updAddr == 1'b1, "R9 first half ua", int'(updAddr), 1);
    pulseRead(); pulseIrq();
    ownAddr = 8'h34; pulseLoad();
    chk(updAddr == 1'b0, "R9 ua cleared", int'(updAddr), 0);
    sendByte(8'h34, ackSeen);
    chk(ackSeen == 1'b1 && rxBuf == 8'h34, "R9 second half", int'(rxBuf), 'h34);
    pulseRead(); pulseIrq();
    sendByte(8'h99, ackSeen);
    chk(ackSeen == 1'b1 && rxBuf == 8'h99, "R11 10-bit data", int'(rxBuf), 'h99);
    pulseRead(); pulseIrq();
    // second half mismatch
    ownAddr = 8'hF2;
    startCond();
    sendByte(8'hF2, ackSeen);
    pulseRead(); pulseIrq();
    ownAddr = 8'h35; pulseLoad();
    sendByte(8'h34, ackSeen);
    chk(ackSeen == 1'b0 && bufFull == 1'b0, "R9 low half mismatch", int'(ackSeen), 0);
    // 10-bit general call
    startCond();
    sendByte(8'h00, ackSeen);
    chk(ackSeen == 1'b1 && updAddr == 1'b0, "R10 gc no ua", int'(updAddr), 0);
    chk(gcFlag == 1'b1, "R10 gc flag", int'(gcFlag), 1);
    pulseRead(); pulseIrq();
    sendByte(8'h5C, ackSeen);
    chk(ackSeen == 1'b1 && rxBuf == 8'h5C, "R10 data after gc", int'(rxBuf), 'h5C);
    stopCond();
    tick(10);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule